// File: doc/BRIEF.md
# Transactional Coherence Directory Controller

This block is a compact directory for a multiprocessor whose cores run memory transactions. For each tracked cache line it holds the set of processors that share the line, a flag for lines that a running transaction has written (pending), a flag for lines that are owned, and the owner's processor number. A single command port carries one operation per cycle. The operations update sharers, set or clear the flags, query state, or produce a forward-request toward the owner of a line. Every accepted command gives a registered response one cycle later.

Transactions commit in the order of their transaction IDs. A next-to-serve ID register decides which transaction may commit. A skip vector records IDs that will never commit, and the register steps over those IDs by itself, one ID per cycle. An accepted commit turns every pending line into an owned line in the same cycle. It strips all sharers other than the owner, and it queues one invalidation for each stripped (line, processor) pair. The invalidations leave on a valid/ready stream. While any of them is still queued, the block raises `busy` and ignores commands. An abort drops all pending flags and moves past the current ID.

Invalidation stream rules: `inv_valid` stays high, and `inv_line`/`inv_proc` stay unchanged, until the cycle in which `inv_ready` is high. Holding `inv_ready` low stalls the queue for as long as it is held. The only other effect is that commands keep being ignored.

Top module: `txn_dir`

## Requirements
- R1: A synchronous reset clears every sharer vector, the pending and owned flags, the skip vector and the invalidation queue, and sets the next-to-serve ID to 0. After reset, `busy`, `inv_valid`, `rsp_valid` and `fwd_valid` are low.
- R2: Opcode 1 sets bit `cmd_proc` of the line's sharer vector, and opcode 2 clears it. Every response carries in `rsp_vec` the line's sharer vector as it was before the command, with bit p standing for processor p. Opcode 6 is the plain read of that vector.
- R3: Opcode 3 returns in `rsp_flag` whether `cmd_proc` is a sharer of the line. Opcode 4 returns whether the line is pending, and opcode 5 returns whether it is owned. For all other opcodes `rsp_flag` is 0.
- R4: Opcode 7 marks the line pending and records `cmd_proc` as its owner-to-be. Opcode 9 makes the line owned by `cmd_proc`. Each of the two is carried out only if `cmd_proc` is a sharer of the line. Otherwise it changes nothing and returns `rsp_err`=1. Opcode 8 clears the pending flag, and opcode 10 clears the owned flag.
- R5: Opcode 11 with `cmd_tid` equal to the next-to-serve ID does three things. It turns every pending line into an owned line and clears its pending flag. It reduces each such line's sharers to the owner alone. It advances the next-to-serve ID by one. With any other `cmd_tid`, it returns `rsp_err`=1 and changes nothing.
- R6: Each stripped (line, processor) pair of a commit is offered once on the invalidation stream. The order is lowest line first, then lowest processor. An offered pair is held stable while `inv_ready` is low. `busy` equals "pairs remain". A command presented while `busy` is high is ignored and gives no response.
- R7: Opcode 12 clears every pending flag, leaves the owned flags unchanged, and advances the next-to-serve ID by one.
- R8: Opcode 13 sets skip-vector bit `cmd_tid mod SKIP_LEN`. In any cycle with no accepted opcode 11, 12 or 13, if the skip bit at (next-to-serve ID mod `SKIP_LEN`) is set, the block clears that bit and advances the ID by one.
- R9: Every response returns in `rsp_tid` the next-to-serve ID before the command. Opcode 14 reads it that way without changing any state.
- R10: Opcode 15 pulses `fwd_valid` one cycle later, with `fwd_owner`, `fwd_line` and `fwd_proc`, when the line is owned by a processor other than `cmd_proc`. Otherwise it gives no pulse. Opcode 0 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 4 | Opcode, encoded as in R2 to R10 |
| cmd_line | input | log2(NUM_LINES) | Target line |
| cmd_proc | input | log2(NUM_PROCS) | Processor argument |
| cmd_tid | input | TID_W | Transaction ID argument |
| busy | output | 1 | Invalidations pending; commands ignored |
| rsp_valid | output | 1 | Response for the command of the previous cycle |
| rsp_flag | output | 1 | Query result |
| rsp_err | output | 1 | Command was rejected |
| rsp_vec | output | NUM_PROCS | Sharer vector of the line |
| rsp_tid | output | TID_W | Next-to-serve ID |
| fwd_valid | output | 1 | Forward-request pulse |
| fwd_owner | output | log2(NUM_PROCS) | Destination owner |
| fwd_line | output | log2(NUM_LINES) | Requested line |
| fwd_proc | output | log2(NUM_PROCS) | Requesting processor |
| inv_valid | output | 1 | Invalidation offered |
| inv_ready | input | 1 | Invalidation taken |
| inv_line | output | log2(NUM_LINES) | Line to invalidate |
| inv_proc | output | log2(NUM_PROCS) | Processor to invalidate |

## Verification
The bench builds the block with 4 lines, 4 processors, a 6-bit ID and an 8-entry skip vector. With so few lines and processors, random commands keep hitting the same lines, so commits regularly strip several sharers at once and exercise the invalidation order under back-pressure. The small ID width makes the next-to-serve ID wrap through 0 during the run. Skips a few IDs ahead exercise the self-advance chain and the modulo indexing of the skip vector.

// File: rtl/txn_dir_pkg.sv
package txn_dir_pkg;
  typedef enum logic [3:0] {
    OP_NOP     = 4'd0,
    OP_ADD     = 4'd1,
    OP_REM     = 4'd2,
    OP_IS_SH   = 4'd3,
    OP_IS_PEND = 4'd4,
    OP_IS_OWN  = 4'd5,
    OP_GET     = 4'd6,
    OP_PEND    = 4'd7,
    OP_UNPEND  = 4'd8,
    OP_OWN     = 4'd9,
    OP_UNOWN   = 4'd10,
    OP_COMMIT  = 4'd11,
    OP_ABORT   = 4'd12,
    OP_SKIP    = 4'd13,
    OP_PROBE   = 4'd14,
    OP_ACCESS  = 4'd15
  } dir_op_e;
endpackage

// File: rtl/txn_dir_lines.sv
module txn_dir_lines #(
  parameter int NL = 8,
  parameter int NP = 4,
  localparam int LW = (NL > 1) ? $clog2(NL) : 1,
  localparam int PW = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd_add,
  input  logic          upd_rem,
  input  logic          upd_pend,
  input  logic          upd_unpend,
  input  logic          upd_own,
  input  logic          upd_unown,
  input  logic          upd_commit,
  input  logic          upd_abort,
  input  logic [LW-1:0] line,
  input  logic [PW-1:0] proc,
  output logic [NP-1:0] sharers [NL],
  output logic [NL-1:0] marked,
  output logic [NL-1:0] owned,
  output logic [PW-1:0] owner [NL],
  output logic [NP-1:0] strip [NL]
);
  for (genvar g = 0; g < NL; g++) begin : g_line
    logic [NP-1:0] sh_q;
    logic          pend_q, own_q;
    logic [PW-1:0] who_q;
    logic [NP-1:0] who_bit;
    logic          hit;

    assign who_bit = NP'(1) << who_q;
    assign hit     = (line == LW'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        sh_q   <= '0;
        pend_q <= 1'b0;
        own_q  <= 1'b0;
        who_q  <= '0;
      end else if (upd_commit && pend_q) begin
        sh_q   <= sh_q & who_bit;
        own_q  <= 1'b1;
        pend_q <= 1'b0;
      end else if (upd_abort) begin
        pend_q <= 1'b0;
      end else if (hit) begin
        if (upd_add)    sh_q[proc] <= 1'b1;
        if (upd_rem)    sh_q[proc] <= 1'b0;
        if (upd_pend)   begin pend_q <= 1'b1; who_q <= proc; end
        if (upd_unpend) pend_q <= 1'b0;
        if (upd_own)    begin own_q <= 1'b1; who_q <= proc; end
        if (upd_unown)  own_q <= 1'b0;
      end
    end

    assign sharers[g] = sh_q;
    assign marked[g]  = pend_q;
    assign owned[g]   = own_q;
    assign owner[g]   = who_q;
    assign strip[g]   = pend_q ? (sh_q & ~who_bit) : '0;
  end
endmodule

// File: rtl/txn_dir_seq.sv
module txn_dir_seq #(
  parameter int TID_W    = 6,
  parameter int SKIP_LEN = 8,
  localparam int IW = (SKIP_LEN > 1) ? $clog2(SKIP_LEN) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             bump,
  input  logic             skip_set,
  input  logic [TID_W-1:0] skip_tid,
  output logic [TID_W-1:0] nsid
);
  logic [SKIP_LEN-1:0] skip_q;
  logic [IW-1:0]       cur_idx, new_idx;

  assign cur_idx = nsid[IW-1:0];
  assign new_idx = skip_tid[IW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      nsid   <= '0;
      skip_q <= '0;
    end else if (hold) begin
      if (bump)     nsid <= nsid + 1'b1;
      if (skip_set) skip_q[new_idx] <= 1'b1;
    end else if (skip_q[cur_idx]) begin
      skip_q[cur_idx] <= 1'b0;
      nsid            <= nsid + 1'b1;
    end
  end
endmodule

// File: rtl/txn_dir_invq.sv
module txn_dir_invq #(
  parameter int NL = 8,
  parameter int NP = 4,
  localparam int LW  = (NL > 1) ? $clog2(NL) : 1,
  localparam int PW  = (NP > 1) ? $clog2(NP) : 1,
  localparam int TOT = NL * NP
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [NP-1:0] load_vec [NL],
  input  logic          inv_ready,
  output logic          inv_valid,
  output logic [LW-1:0] inv_line,
  output logic [PW-1:0] inv_proc
);
  logic [TOT-1:0] pend_q, load_flat, take;
  int             sel;

  always_comb begin
    for (int l = 0; l < NL; l++)
      for (int p = 0; p < NP; p++)
        load_flat[l*NP + p] = load_vec[l][p];
  end

  always_comb begin
    sel = 0;
    for (int k = TOT - 1; k >= 0; k--)
      if (pend_q[k]) sel = k;
  end

  assign inv_valid = |pend_q;
  assign inv_line  = LW'(sel / NP);
  assign inv_proc  = PW'(sel % NP);
  assign take      = (inv_valid && inv_ready) ? (TOT'(1) << sel) : '0;

  always_ff @(posedge clk) begin
    if (rst)       pend_q <= '0;
    else if (load) pend_q <= load_flat;
    else           pend_q <= pend_q & ~take;
  end
endmodule

// File: rtl/txn_dir.sv
module txn_dir
  import txn_dir_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int NUM_PROCS = 4,
  parameter int TID_W     = 6,
  parameter int SKIP_LEN  = 8,
  localparam int LW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int PW = (NUM_PROCS > 1) ? $clog2(NUM_PROCS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_valid,
  input  logic [3:0]           cmd_op,
  input  logic [LW-1:0]        cmd_line,
  input  logic [PW-1:0]        cmd_proc,
  input  logic [TID_W-1:0]     cmd_tid,
  output logic                 busy,
  output logic                 rsp_valid,
  output logic                 rsp_flag,
  output logic                 rsp_err,
  output logic [NUM_PROCS-1:0] rsp_vec,
  output logic [TID_W-1:0]     rsp_tid,
  output logic                 fwd_valid,
  output logic [PW-1:0]        fwd_owner,
  output logic [LW-1:0]        fwd_line,
  output logic [PW-1:0]        fwd_proc,
  output logic                 inv_valid,
  input  logic                 inv_ready,
  output logic [LW-1:0]        inv_line,
  output logic [PW-1:0]        inv_proc
);
  dir_op_e                op;
  logic                   acc, is_sh, commit_ok, hold;
  logic [TID_W-1:0]       nsid;
  logic [NUM_PROCS-1:0]   sharers [NUM_LINES];
  logic [NUM_PROCS-1:0]   strip   [NUM_LINES];
  logic [PW-1:0]          owner   [NUM_LINES];
  logic [NUM_LINES-1:0]   marked, owned;
  logic                   flag_d, err_d, fwd_d;

  assign op        = dir_op_e'(cmd_op);
  assign busy      = inv_valid;
  assign acc       = cmd_valid && !busy;
  assign is_sh     = sharers[cmd_line][cmd_proc];
  assign commit_ok = (op == OP_COMMIT) && (cmd_tid == nsid);
  assign hold      = acc && (op == OP_COMMIT || op == OP_ABORT || op == OP_SKIP);

  txn_dir_lines #(.NL(NUM_LINES), .NP(NUM_PROCS)) u_lines (
    .clk        (clk),
    .rst        (rst),
    .upd_add    (acc && op == OP_ADD),
    .upd_rem    (acc && op == OP_REM),
    .upd_pend   (acc && op == OP_PEND && is_sh),
    .upd_unpend (acc && op == OP_UNPEND),
    .upd_own    (acc && op == OP_OWN && is_sh),
    .upd_unown  (acc && op == OP_UNOWN),
    .upd_commit (acc && commit_ok),
    .upd_abort  (acc && op == OP_ABORT),
    .line       (cmd_line),
    .proc       (cmd_proc),
    .sharers    (sharers),
    .marked     (marked),
    .owned      (owned),
    .owner      (owner),
    .strip      (strip)
  );

  txn_dir_seq #(.TID_W(TID_W), .SKIP_LEN(SKIP_LEN)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .hold     (hold),
    .bump     (commit_ok || op == OP_ABORT),
    .skip_set (op == OP_SKIP),
    .skip_tid (cmd_tid),
    .nsid     (nsid)
  );

  txn_dir_invq #(.NL(NUM_LINES), .NP(NUM_PROCS)) u_invq (
    .clk       (clk),
    .rst       (rst),
    .load      (acc && commit_ok),
    .load_vec  (strip),
    .inv_ready (inv_ready),
    .inv_valid (inv_valid),
    .inv_line  (inv_line),
    .inv_proc  (inv_proc)
  );

  always_comb begin
    unique case (op)
      OP_IS_SH:   flag_d = is_sh;
      OP_IS_PEND: flag_d = marked[cmd_line];
      OP_IS_OWN:  flag_d = owned[cmd_line];
      default:    flag_d = 1'b0;
    endcase
    unique case (op)
      OP_PEND, OP_OWN: err_d = !is_sh;
      OP_COMMIT:       err_d = !commit_ok;
      default:         err_d = 1'b0;
    endcase
    fwd_d = (op == OP_ACCESS) && owned[cmd_line] && (owner[cmd_line] != cmd_proc);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_flag  <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_vec   <= '0;
      rsp_tid   <= '0;
      fwd_valid <= 1'b0;
      fwd_owner <= '0;
      fwd_line  <= '0;
      fwd_proc  <= '0;
    end else begin
      rsp_valid <= acc;
      fwd_valid <= acc && fwd_d;
      if (acc) begin
        rsp_flag  <= flag_d;
        rsp_err   <= err_d;
        rsp_vec   <= sharers[cmd_line];
        rsp_tid   <= nsid;
        fwd_owner <= owner[cmd_line];
        fwd_line  <= cmd_line;
        fwd_proc  <= cmd_proc;
      end
    end
  end
endmodule

// File: rtl/txn_dir_chk.sv
module txn_dir_chk
  import txn_dir_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int NUM_PROCS = 4,
  parameter int TID_W     = 6,
  localparam int LW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int PW = (NUM_PROCS > 1) ? $clog2(NUM_PROCS) : 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 acc,
  input logic [3:0]           cmd_op,
  input logic [LW-1:0]        cmd_line,
  input logic [PW-1:0]        cmd_proc,
  input logic [TID_W-1:0]     cmd_tid,
  input logic [TID_W-1:0]     nsid,
  input logic [NUM_LINES-1:0] marked,
  input logic [NUM_LINES-1:0] owned,
  input logic [NUM_PROCS-1:0] sharers [NUM_LINES],
  input logic                 busy,
  input logic                 inv_valid,
  input logic                 inv_ready,
  input logic [LW-1:0]        inv_line,
  input logic [PW-1:0]        inv_proc,
  input logic                 rsp_valid,
  input logic                 rsp_err,
  input logic [TID_W-1:0]     rsp_tid,
  input logic                 fwd_valid,
  input logic [PW-1:0]        fwd_owner,
  input logic [PW-1:0]        fwd_proc
);
  assert_inv_hold_R6: assert property (@(posedge clk) disable iff (rst)
    inv_valid && !inv_ready |=> inv_valid && $stable(inv_line) && $stable(inv_proc));

  assert_busy_ignore_R6: assert property (@(posedge clk) disable iff (rst)
    busy |=> !rsp_valid);

  assert_own_reject_R4: assert property (@(posedge clk) disable iff (rst)
    acc && cmd_op == OP_OWN && !sharers[cmd_line][cmd_proc] |=> rsp_err && owned == $past(owned));

  assert_commit_clears_R5: assert property (@(posedge clk) disable iff (rst)
    acc && cmd_op == OP_COMMIT && cmd_tid == nsid |=> marked == '0 && nsid == TID_W'($past(nsid) + 1'b1));

  assert_abort_R7: assert property (@(posedge clk) disable iff (rst)
    acc && cmd_op == OP_ABORT |=> marked == '0 && owned == $past(owned) && nsid == TID_W'($past(nsid) + 1'b1));

  assert_step_R8: assert property (@(posedge clk) disable iff (rst)
    nsid != $past(nsid) |-> nsid == TID_W'($past(nsid) + 1'b1));

  assert_probe_R9: assert property (@(posedge clk) disable iff (rst)
    acc && cmd_op == OP_PROBE |=> rsp_tid == $past(nsid) && $stable(marked) && $stable(owned));

  assert_fwd_other_R10: assert property (@(posedge clk) disable iff (rst)
    fwd_valid |-> fwd_owner != fwd_proc);
endmodule

bind txn_dir txn_dir_chk #(.NUM_LINES(NUM_LINES), .NUM_PROCS(NUM_PROCS), .TID_W(TID_W)) u_chk (.*);

// File: tb/tb_txn_dir.sv
module tb_txn_dir;
  import txn_dir_pkg::*;
  localparam int NL = 4, NP = 4, TW = 6, SL = 8;
  localparam int LW = 2, PW = 2;

  logic clk = 1'b0, rst = 1'b1;
  always #4 clk = ~clk;

  logic cmd_valid = 0, inv_ready = 0;
  logic [3:0] cmd_op = 0;
  logic [LW-1:0] cmd_line = 0;
  logic [PW-1:0] cmd_proc = 0;
  logic [TW-1:0] cmd_tid = 0;
  logic busy, rsp_valid, rsp_flag, rsp_err, fwd_valid, inv_valid;
  logic [NP-1:0] rsp_vec;
  logic [TW-1:0] rsp_tid;
  logic [PW-1:0] fwd_owner, fwd_proc, inv_proc;
  logic [LW-1:0] fwd_line, inv_line;

  txn_dir #(.NUM_LINES(NL), .NUM_PROCS(NP), .TID_W(TW), .SKIP_LEN(SL)) dut (.*);

  logic [NP-1:0] m_sh [NL];
  logic [NP-1:0] m_pd [NL];
  logic [PW-1:0] m_who [NL];
  logic          m_mk [NL];
  logic          m_ow [NL];
  logic [TW-1:0] m_ns;
  logic [SL-1:0] m_sk;
  int n_tests = 0, n_fail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic m_busy();
    logic b = 0;
    for (int l = 0; l < NL; l++) b |= |m_pd[l];
    return b;
  endfunction

  task automatic m_reset();
    for (int l = 0; l < NL; l++) begin
      m_sh[l] = 0; m_pd[l] = 0; m_who[l] = 0; m_mk[l] = 0; m_ow[l] = 0;
    end
    m_ns = 0; m_sk = 0;
  endtask

  task automatic step(input logic v, input logic [3:0] op, input int ln, input int pr,
                      input logic [TW-1:0] tid, input logic rdy);
    logic acc, e_iv, e_flag, e_err, e_fwd, e_sh, hold;
    logic [NP-1:0] e_vec;
    logic [TW-1:0] e_tid;
    logic [PW-1:0] e_own;
    int il, ip;
    cmd_valid = v; cmd_op = op; cmd_line = LW'(ln); cmd_proc = PW'(pr);
    cmd_tid = tid; inv_ready = rdy;
    #1;
    e_iv = m_busy();
    il = 0; ip = 0;
    for (int k = NL*NP - 1; k >= 0; k--)
      if (m_pd[k/NP][k%NP]) begin il = k/NP; ip = k%NP; end
    chk("R6 busy", busy, e_iv);
    chk("R6 inv_valid", inv_valid, e_iv);
    if (e_iv) begin
      chk("R6 inv_line", inv_line, il);
      chk("R6 inv_proc", inv_proc, ip);
    end
    acc = v && !e_iv;
    e_sh = m_sh[ln][pr];
    e_vec = m_sh[ln]; e_tid = m_ns; e_own = m_who[ln];
    e_flag = (op == OP_IS_SH) ? e_sh : (op == OP_IS_PEND) ? m_mk[ln] :
             (op == OP_IS_OWN) ? m_ow[ln] : 1'b0;
    e_err = ((op == OP_PEND || op == OP_OWN) && !e_sh) || (op == OP_COMMIT && tid != m_ns);
    e_fwd = acc && op == OP_ACCESS && m_ow[ln] && m_who[ln] != PW'(pr);
    @(posedge clk);
    if (e_iv && rdy) m_pd[il][ip] = 1'b0;
    hold = acc && (op == OP_COMMIT || op == OP_ABORT || op == OP_SKIP);
    if (acc) begin
      case (op)
        OP_ADD:    m_sh[ln][pr] = 1'b1;
        OP_REM:    m_sh[ln][pr] = 1'b0;
        OP_PEND:   if (e_sh) begin m_mk[ln] = 1; m_who[ln] = PW'(pr); end
        OP_UNPEND: m_mk[ln] = 0;
        OP_OWN:    if (e_sh) begin m_ow[ln] = 1; m_who[ln] = PW'(pr); end
        OP_UNOWN:  m_ow[ln] = 0;
        OP_COMMIT: if (tid == m_ns) begin
          for (int l = 0; l < NL; l++) if (m_mk[l]) begin
            m_pd[l] = m_sh[l] & ~(NP'(1) << m_who[l]);
            m_sh[l] = m_sh[l] & (NP'(1) << m_who[l]);
            m_ow[l] = 1; m_mk[l] = 0;
          end
          m_ns = m_ns + 1'b1;
        end
        OP_ABORT: begin
          for (int l = 0; l < NL; l++) m_mk[l] = 0;
          m_ns = m_ns + 1'b1;
        end
        OP_SKIP:  m_sk[tid % SL] = 1'b1;
        default: ;
      endcase
    end
    if (!hold && m_sk[m_ns % SL]) begin
      m_sk[m_ns % SL] = 1'b0;
      m_ns = m_ns + 1'b1;
    end
    @(negedge clk);
    chk("R6 rsp_valid", rsp_valid, acc);
    if (acc) begin
      chk("R3 rsp_flag", rsp_flag, e_flag);
      chk("R2 rsp_vec", rsp_vec, e_vec);
      chk("R4 rsp_err", rsp_err, e_err);
      chk("R9 rsp_tid", rsp_tid, e_tid);
    end
    chk("R10 fwd_valid", fwd_valid, e_fwd);
    if (e_fwd) begin
      chk("R10 fwd_owner", fwd_owner, e_own);
      chk("R10 fwd_line", fwd_line, ln);
      chk("R10 fwd_proc", fwd_proc, pr);
    end
  endtask

  task automatic cmd(input logic [3:0] op, input int ln, input int pr, input logic [TW-1:0] tid);
    step(1'b1, op, ln, pr, tid, 1'b1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, OP_NOP, 0, 0, '0, 1'b1);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1dc0_7a11));
    m_reset();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 inv_valid", inv_valid, 0);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 fwd_valid", fwd_valid, 0);
    cmd(OP_PROBE, 0, 0, 0);
    chk("R1 nsid zero", rsp_tid, 0);
    for (int l = 0; l < NL; l++) cmd(OP_GET, l, 0, 0);

    // R2 sharers, R4 illegal owner
    cmd(OP_ADD, 2, 1, 0); cmd(OP_ADD, 2, 3, 0); cmd(OP_ADD, 2, 0, 0);
    cmd(OP_GET, 2, 0, 0);
    chk("R2 vector", rsp_vec, 4'b1011);
    cmd(OP_OWN, 1, 2, 0);
    chk("R4 reject", rsp_err, 1);
    cmd(OP_IS_OWN, 1, 0, 0);
    chk("R4 unchanged", rsp_flag, 0);

    // R5 commit with wrong and right ID, R6 drain under back-pressure
    cmd(OP_PEND, 2, 1, 0);
    cmd(OP_COMMIT, 0, 0, 6'd5);
    chk("R5 wrong id rejected", rsp_err, 1);
    cmd(OP_COMMIT, 0, 0, 6'd0);
    chk("R5 accepted", rsp_err, 0);
    step(1'b1, OP_ADD, 3, 2, 0, 1'b0);
    step(1'b0, OP_NOP, 0, 0, 0, 1'b0);
    step(1'b0, OP_NOP, 0, 0, 0, 1'b1);
    step(1'b0, OP_NOP, 0, 0, 0, 1'b1);
    chk("R6 drained", busy, 0);
    cmd(OP_GET, 3, 0, 0);
    chk("R6 ignored while busy", rsp_vec, 0);
    cmd(OP_PROBE, 0, 0, 0);
    chk("R5 nsid after commit", rsp_tid, 1);
    cmd(OP_GET, 2, 0, 0);
    chk("R5 only owner left", rsp_vec, 4'b0010);

    // R7 abort
    cmd(OP_ADD, 0, 3, 0); cmd(OP_PEND, 0, 3, 0);
    cmd(OP_ABORT, 0, 0, 0);
    cmd(OP_IS_PEND, 0, 0, 0);
    chk("R7 pending cleared", rsp_flag, 0);
    chk("R7 nsid advanced", rsp_tid, 2);
    cmd(OP_IS_OWN, 2, 0, 0);
    chk("R7 owned kept", rsp_flag, 1);

    // R8 skip chain
    cmd(OP_SKIP, 0, 0, 6'd4); cmd(OP_SKIP, 0, 0, 6'd3); cmd(OP_SKIP, 0, 0, 6'd2);
    idle(3);
    cmd(OP_PROBE, 0, 0, 0);
    chk("R8 chain advanced", rsp_tid, 5);

    // R10 forward
    cmd(OP_ACCESS, 2, 2, 0);
    chk("R10 forward to owner", fwd_valid, 1);
    cmd(OP_ACCESS, 2, 1, 0);
    chk("R10 owner no forward", fwd_valid, 0);

    // constrained random
    for (int i = 0; i < 6000; i++) begin
      logic [3:0] op;
      logic [TW-1:0] t;
      int r = $urandom % 20;
      op = (r >= 16) ? OP_ADD : 4'(r);
      t = TW'($urandom);
      if (op == OP_COMMIT && ($urandom % 4 != 0)) t = m_ns;
      if (op == OP_SKIP) t = m_ns + TW'($urandom % 5);
      step($urandom % 8 != 0, op, $urandom % NL, $urandom % NP, t, $urandom % 4 != 0);
    end
    while (m_busy()) idle(1);
    idle(2);
    finish_run();
  end
endmodule